// File: doc/BRIEF.md
# Debug Command Frame Sequencer

This block is the command layer of a single-wire debug port. It sits above a bit transceiver that handles bit timing. That transceiver hands it one strobe per bit time: the host's bit during receive phases, or a strobe saying the current output bit has gone out during transmit phases. It also reports a frame timeout. Each frame opens with an 8-bit command. The top two command bits pick a class, and the class decides which phases follow: a 16-bit address, 16-bit write data, or 16-bit read data sent back to the host. A fixed delay counted in bus clocks separates the phases.

The sequencer issues one-cycle read, write and execute requests to a simple memory/CPU port. Alongside each request it presents the latched command, address and write data. The read data is sampled when the read delay ends. It is then shifted out MSB first. A `ready` output tells the transceiver that the next command may start.

The state machine has five states. S_CMD receives the command and drives `ready` while no command bit has arrived. S_ADDR receives the address. S_DIN receives write data. S_WAIT counts a fixed delay. S_DOUT transmits read data. The transitions are:
- S_CMD to S_ADDR for hardware classes.
- S_CMD to S_DIN for a firmware write.
- S_CMD to S_WAIT for a firmware read or go/trace.
- S_ADDR to S_WAIT for a hardware read.
- S_ADDR to S_DIN for a hardware write.
- S_DIN to S_WAIT.
- S_WAIT to S_DOUT for reads.
- S_WAIT to S_CMD for all other classes.
- S_DOUT to S_CMD after the 16th bit.
- Any state to S_CMD on timeout.

Top module: `dbg_frame_seq`

## Requirements
- R1: After reset `ready` is 1, `tx_en` is 0 and no request output is high.
- R2: Command bits [7:6] select the class: 00 go/trace, 01 firmware, 10 hardware read, 11 hardware write. Within the firmware class, bit 5 = 1 means read and bit 5 = 0 means write. `req_fw` is 1 for firmware requests and 0 for hardware requests.
- R3: Hardware read timing. `rd_req` pulses with `req_addr` valid in the cycle after the 16th address bit. `tx_en` rises 150 cycles after that final address strobe edge. After the 16th transmit strobe, `ready` returns.
- R4: Hardware write timing. `wr_req` pulses with `req_addr` and `req_wdata` valid in the cycle after the last data bit. `ready` returns 150 cycles after that edge.
- R5: Firmware read timing. `rd_req` with `req_fw`=1 pulses after the 8th command bit. `tx_en` rises 48 cycles later. 16 data bits then go out.
- R6: Firmware write timing. The command is followed by 16 data bits. `wr_req` with `req_fw`=1 pulses after the last data bit. `ready` returns 36 cycles later.
- R7: Go/trace timing. `exec_req` pulses after the 8th command bit with `req_cmd` valid. `ready` returns 76 cycles later.
- R8: Received fields are assembled MSB first. Read data is sampled from `mem_rdata` when the read delay ends and is sent MSB first on `tx_bit`.
- R9: Bit strobes during a delay are ignored and do not change its length.
- R10: `bit_timeout` aborts any frame without issuing a further request, and `ready` is 1 in the next cycle.
- R11: At most one of `rd_req`, `wr_req`, `exec_req` is high in any cycle, and each is a single-cycle pulse.
- R12: `ready` is 0 from the first command bit until the frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bus clock |
| rst_n | input | 1 | active-low reset |
| bit_stb | input | 1 | one bit time done (received bit valid, or output bit sent) |
| bit_in | input | 1 | received bit, valid with `bit_stb` |
| bit_timeout | input | 1 | frame timeout from the bit layer |
| tx_en | output | 1 | sequencer is transmitting read data |
| tx_bit | output | 1 | current bit to send |
| ready | output | 1 | next command may begin |
| mem_rdata | input | 16 | read data from memory/CPU port |
| rd_req | output | 1 | read request pulse |
| wr_req | output | 1 | write request pulse |
| exec_req | output | 1 | go/trace request pulse |
| req_fw | output | 1 | request belongs to the firmware class |
| req_cmd | output | 8 | latched command |
| req_addr | output | 16 | latched address |
| req_wdata | output | 16 | latched write data |

## Verification
Request pulses and latched fields are registered on the clock edge that takes the last bit of their phase. They are therefore checked at the falling edge directly after the strobe that carries that bit. A delay of D cycles ends on the D-th rising edge after that strobe edge. For each delay, the bench checks the affected output still inactive after D-1 edges and active after D, so that a delay off by one in either direction is reported. Transmitted bits are compared at the falling edge before each transmit strobe. `ready` is checked in the cycle after the 16th transmit strobe or after the timeout.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

    typedef enum logic [1:0] {
        CLS_GO  = 2'b00,
        CLS_FW  = 2'b01,
        CLS_HRD = 2'b10,
        CLS_HWR = 2'b11
    } cls_e;

    typedef enum logic [2:0] {
        S_CMD,
        S_ADDR,
        S_DIN,
        S_WAIT,
        S_DOUT
    } st_e;

    function automatic cls_e cls_of(input logic [7:0] code);
        return cls_e'(code[7:6]);
    endfunction

    function automatic logic fw_is_read(input logic [7:0] code);
        return code[5];
    endfunction

endpackage

// File: rtl/dsq_shift_in.sv
module dsq_shift_in #(
    parameter int W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       stb,
    input  logic                       bit_in,
    output logic [W-1:0]               word_next,
    output logic [$clog2(W+1)-1:0]     cnt
);
    localparam int CW = $clog2(W+1);

    logic [W-1:0] word_q;

    assign word_next = {word_q[W-2:0], bit_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            cnt    <= '0;
        end else if (clr) begin
            word_q <= '0;
            cnt    <= '0;
        end else if (stb) begin
            word_q <= word_next;
            cnt    <= cnt + CW'(1);
        end
    end

    // R8: the count is cleared on the last bit of a phase, so it never reaches W
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(W));

endmodule

// File: rtl/dsq_shift_out.sv
module dsq_shift_out #(
    parameter int W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [W-1:0]               data,
    input  logic                       stb,
    output logic                       bit_out,
    output logic [$clog2(W+1)-1:0]     cnt
);
    localparam int CW = $clog2(W+1);

    logic [W-1:0] sh_q;

    assign bit_out = sh_q[W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
            cnt  <= '0;
        end else if (load) begin
            sh_q <= data;
            cnt  <= '0;
        end else if (stb) begin
            sh_q <= {sh_q[W-2:0], 1'b0};
            cnt  <= cnt + CW'(1);
        end
    end

    // R8: a load always restarts the bit count
    a_r8_load_restart: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == '0);

endmodule

// File: rtl/dsq_delay.sv
module dsq_delay #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [DW-1:0] val,
    output logic          done
);
    logic [DW-1:0] cnt_q;

    assign done = (cnt_q == DW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (load)
            cnt_q <= val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - DW'(1);
    end

    // R9: once done, the counter is idle until the next load
    a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done && !load |=> !done);

endmodule

// File: rtl/dbg_frame_seq.sv
module dbg_frame_seq
    import dsq_pkg::*;
#(
    parameter int CMD_W  = 8,
    parameter int WORD_W = 16,
    parameter int DLY_HW = 150,
    parameter int DLY_FR = 48,
    parameter int DLY_FW = 36,
    parameter int DLY_GO = 76
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              bit_in,
    input  logic              bit_timeout,
    output logic              tx_en,
    output logic              tx_bit,
    output logic              ready,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              rd_req,
    output logic              wr_req,
    output logic              exec_req,
    output logic              req_fw,
    output logic [CMD_W-1:0]  req_cmd,
    output logic [WORD_W-1:0] req_addr,
    output logic [WORD_W-1:0] req_wdata
);
    localparam int CW      = $clog2(WORD_W + 1);
    localparam int MAX_A   = (DLY_HW > DLY_FR) ? DLY_HW : DLY_FR;
    localparam int MAX_B   = (DLY_FW > DLY_GO) ? DLY_FW : DLY_GO;
    localparam int DLY_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int DW      = $clog2(DLY_MAX + 1);

    st_e               state, state_nx;
    logic              rx_phase, last_rx, last_tx;
    logic              sh_clr, sh_stb;
    logic [WORD_W-1:0] sh_next;
    logic [CW-1:0]     sh_cnt, tx_cnt;
    logic [CW-1:0]     phase_len;
    logic [CMD_W-1:0]  cmd_now;
    cls_e              cls_now, cls_q;
    logic              reading;
    logic              dly_load, dly_done;
    logic [DW-1:0]     dly_val;
    logic              tx_load;

    assign cmd_now = sh_next[CMD_W-1:0];
    assign cls_now = cls_of(cmd_now);
    assign cls_q   = cls_of(req_cmd);
    assign reading = (cls_q == CLS_HRD) || (cls_q == CLS_FW && fw_is_read(req_cmd));

    assign rx_phase  = (state == S_CMD) || (state == S_ADDR) || (state == S_DIN);
    assign phase_len = (state == S_CMD) ? CW'(CMD_W) : CW'(WORD_W);
    assign last_rx   = rx_phase && bit_stb && (sh_cnt == phase_len - CW'(1));
    assign last_tx   = (state == S_DOUT) && bit_stb && (tx_cnt == CW'(WORD_W - 1));

    assign sh_stb  = rx_phase && bit_stb;
    assign sh_clr  = bit_timeout || last_rx;

    dsq_shift_in #(.W(WORD_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (sh_clr),
        .stb       (sh_stb),
        .bit_in    (bit_in),
        .word_next (sh_next),
        .cnt       (sh_cnt)
    );

    // Next-state decode and delay selection
    always_comb begin
        state_nx = state;
        dly_val  = '0;
        unique case (state)
            S_CMD: begin
                if (last_rx) begin
                    unique case (cls_now)
                        CLS_GO: begin
                            state_nx = S_WAIT;
                            dly_val  = DW'(DLY_GO);
                        end
                        CLS_FW: begin
                            if (fw_is_read(cmd_now)) begin
                                state_nx = S_WAIT;
                                dly_val  = DW'(DLY_FR);
                            end else begin
                                state_nx = S_DIN;
                            end
                        end
                        default: state_nx = S_ADDR;
                    endcase
                end
            end
            S_ADDR: begin
                if (last_rx) begin
                    if (cls_q == CLS_HRD) begin
                        state_nx = S_WAIT;
                        dly_val  = DW'(DLY_HW);
                    end else begin
                        state_nx = S_DIN;
                    end
                end
            end
            S_DIN: begin
                if (last_rx) begin
                    state_nx = S_WAIT;
                    dly_val  = (cls_q == CLS_FW) ? DW'(DLY_FW) : DW'(DLY_HW);
                end
            end
            S_WAIT: begin
                if (dly_done)
                    state_nx = reading ? S_DOUT : S_CMD;
            end
            S_DOUT: begin
                if (last_tx)
                    state_nx = S_CMD;
            end
            default: state_nx = S_CMD;
        endcase
        if (bit_timeout)
            state_nx = S_CMD;
    end

    assign dly_load = (state != S_WAIT) && (state_nx == S_WAIT);
    assign tx_load  = (state == S_WAIT) && (state_nx == S_DOUT);

    dsq_delay #(.DW(DW)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (bit_timeout),
        .load  (dly_load),
        .val   (dly_val),
        .done  (dly_done)
    );

    dsq_shift_out #(.W(WORD_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tx_load),
        .data    (mem_rdata),
        .stb     ((state == S_DOUT) && bit_stb),
        .bit_out (tx_bit),
        .cnt     (tx_cnt)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_CMD;
        else
            state <= state_nx;
    end

    // Registered request outputs and field latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_req    <= 1'b0;
            wr_req    <= 1'b0;
            exec_req  <= 1'b0;
            req_fw    <= 1'b0;
            req_cmd   <= '0;
            req_addr  <= '0;
            req_wdata <= '0;
        end else begin
            rd_req   <= 1'b0;
            wr_req   <= 1'b0;
            exec_req <= 1'b0;
            if (last_rx && !bit_timeout) begin
                unique case (state)
                    S_CMD: begin
                        req_cmd  <= cmd_now;
                        req_fw   <= (cls_now == CLS_FW);
                        exec_req <= (cls_now == CLS_GO);
                        rd_req   <= (cls_now == CLS_FW) && fw_is_read(cmd_now);
                    end
                    S_ADDR: begin
                        req_addr <= sh_next;
                        rd_req   <= (cls_q == CLS_HRD);
                    end
                    S_DIN: begin
                        req_wdata <= sh_next;
                        wr_req    <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign ready = (state == S_CMD) && (sh_cnt == '0);
    assign tx_en = (state == S_DOUT);

    // R11: requests are mutually exclusive single-cycle pulses
    a_r11_one_req: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_req, wr_req, exec_req}));
    a_r11_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req || wr_req || exec_req) |=> !(rd_req || wr_req || exec_req));
    // R10: a timeout returns the sequencer to command wait
    a_r10_timeout_ready: assert property (@(posedge clk) disable iff (!rst_n)
        bit_timeout |=> ready && !tx_en);
    // R3: a read request is always followed by a delay, not by ready or transmit
    a_r3_read_waits: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !ready && !tx_en);
    // R4: a write request is followed by a delay before ready
    a_r4_write_waits: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !ready && !tx_en);
    // R9: the wait state holds until the counter expires
    a_r9_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT) && !dly_done && !bit_timeout |=> state == S_WAIT);
    // R12: ready and transmit never overlap
    a_r12_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !tx_en);

endmodule

// File: tb/test_dbg_frame_seq.sv
module test_dbg_frame_seq;
    localparam int CLK_PERIOD = 10;
    localparam int D_HW = 150;
    localparam int D_FR = 48;
    localparam int D_FW = 36;
    localparam int D_GO = 76;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_stb = 1'b0;
    logic        bit_in = 1'b0;
    logic        bit_timeout = 1'b0;
    logic        tx_en, tx_bit, ready;
    logic [15:0] mem_rdata = '0;
    logic        rd_req, wr_req, exec_req, req_fw;
    logic [7:0]  req_cmd;
    logic [15:0] req_addr, req_wdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_frame_seq i_dbg_frame_seq (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_in(bit_in),
        .bit_timeout(bit_timeout), .tx_en(tx_en), .tx_bit(tx_bit), .ready(ready),
        .mem_rdata(mem_rdata), .rd_req(rd_req), .wr_req(wr_req), .exec_req(exec_req),
        .req_fw(req_fw), .req_cmd(req_cmd), .req_addr(req_addr), .req_wdata(req_wdata)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One bit time: strobe held for one rising edge, returns at the next falling edge
    task automatic strobe(input logic b);
        bit_stb = 1'b1;
        bit_in  = b;
        @(negedge clk);
        bit_stb = 1'b0;
    endtask

    task automatic send(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) strobe(v[i]);
    endtask

    // Wait d edges after the phase edge; the watched output must be off after d-1, on after d
    task automatic wait_delay(input int d, input logic inject, input logic watch_tx, input string tag);
        for (int k = 0; k < d - 1; k++) begin
            if (inject && k < 3) strobe(1'b1);  // R9: strobes inside the delay
            else @(negedge clk);
        end
        check(watch_tx ? tx_en : ready, 0, {tag, " early"});
        @(negedge clk);
        check(watch_tx ? tx_en : ready, 1, {tag, " on time"});
    endtask

    task automatic receive(input logic [15:0] exp, input string tag);
        for (int i = 15; i >= 0; i--) begin
            check(tx_bit, exp[i], {tag, " R8 tx bit"});
            strobe(1'b0);
        end
        check(ready, 1, {tag, " ready after tx"});
        check(tx_en, 0, {tag, " tx_en off"});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] addr, wdata;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ready, 1, "R1 ready");
        check(tx_en, 0, "R1 tx_en");
        check({rd_req, wr_req, exec_req}, 0, "R1 no req");
        rst_n = 1'b1;
        @(negedge clk);
        check(ready, 1, "R1 ready after release");

        for (int c = 0; c < 256; c++) begin
            logic [7:0] code;
            code  = 8'(c);
            addr  = {code, ~code};
            wdata = {code ^ 8'h5a, code};
            mem_rdata = {~code, code ^ 8'hc3};
            strobe(code[7]);
            check(ready, 0, "R12 ready low after first bit");
            send({8'h0, code}, 7);
            check(req_cmd, code, "R2 req_cmd");
            check(ready, 0, "R12 ready low after command");
            unique case (code[7:6])
                2'b00: begin
                    check({rd_req, wr_req, exec_req}, 3'b001, "R7 exec_req");
                    wait_delay(D_GO, 1'b0, 1'b0, "R7 go delay");
                end
                2'b01: begin
                    if (code[5]) begin
                        check({rd_req, wr_req, exec_req, req_fw}, 4'b1001, "R5 fw rd_req");
                        wait_delay(D_FR, 1'b0, 1'b1, "R5 fw read delay");
                        receive(mem_rdata, "R5");
                    end else begin
                        check({rd_req, wr_req, exec_req}, 3'b000, "R2 fw write no early req");
                        send(wdata, 16);
                        check({rd_req, wr_req, exec_req, req_fw}, 4'b0101, "R6 fw wr_req");
                        check(req_wdata, wdata, "R6 R8 req_wdata");
                        wait_delay(D_FW, code[0], 1'b0, "R6 fw write delay");
                    end
                end
                2'b10: begin
                    send(addr, 16);
                    check({rd_req, wr_req, exec_req, req_fw}, 4'b1000, "R3 hw rd_req");
                    check(req_addr, addr, "R3 R8 req_addr");
                    wait_delay(D_HW, code[0], 1'b1, "R3 hw read delay");
                    receive(mem_rdata, "R3");
                end
                default: begin
                    send(addr, 16);
                    check({rd_req, wr_req, exec_req}, 3'b000, "R2 hw write no addr req");
                    send(wdata, 16);
                    check({rd_req, wr_req, exec_req, req_fw}, 4'b0100, "R4 hw wr_req");
                    check(req_addr, addr, "R4 req_addr");
                    check(req_wdata, wdata, "R4 R8 req_wdata");
                    wait_delay(D_HW, code[0], 1'b0, "R4 hw write delay");
                end
            endcase
            @(negedge clk);
        end

        // R10: timeout inside the command phase
        send(16'h0003, 3);
        check(ready, 0, "R10 mid command busy");
        bit_timeout = 1'b1;
        @(negedge clk);
        bit_timeout = 1'b0;
        check(ready, 1, "R10 ready after timeout");
        check({rd_req, wr_req, exec_req}, 0, "R10 no req after timeout");

        // R10: timeout inside an address phase, then a clean hardware read
        send(16'h00c0, 8);
        send(16'h0015, 5);
        bit_timeout = 1'b1;
        @(negedge clk);
        bit_timeout = 1'b0;
        check(ready, 1, "R10 ready after addr timeout");
        mem_rdata = 16'hbeef;
        send(16'h0080, 8);
        send(16'h1234, 16);
        check(rd_req, 1, "R10 read after abort");
        check(req_addr, 16'h1234, "R10 addr after abort");
        wait_delay(D_HW, 1'b0, 1'b1, "R10 read delay after abort");
        receive(16'hbeef, "R10");

        // R10: timeout inside a delay
        send(16'h0000, 8);
        repeat (10) @(negedge clk);
        bit_timeout = 1'b1;
        @(negedge clk);
        bit_timeout = 1'b0;
        check(ready, 1, "R10 ready after wait timeout");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule